// File: doc/BRIEF.md
# Two-State Coherent Cache Controller

This block is the cache controller of one node in a system where every node owns a small private cache. A directory keeps all the caches coherent. Each line is either Modified (this node has touched it and no other node has a copy) or Invalid. Loads, instruction fetches and stores follow one path. A request that finds its line Modified with a matching tag completes at once. A request that finds its line Invalid sends an exclusive-ownership request (GETX) to the directory. The core then waits until the fill arrives.

The cache is direct-mapped. Each line holds a tag, a state and one data word. The core holds its request until `core_done` pulses. A replacement trigger from outside names a line to evict, and a DMA-driven invalidation from the directory is treated the same way. An evicted line keeps its data until the directory acknowledges the writeback. If a forwarded request reaches the line in the meantime, the held data goes straight to the requesting node. This closes the race between an eviction and a forward.

Outgoing messages are registered, one per cycle, with no backpressure. Incoming messages are taken one per cycle.

Top module: `mi_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, `msg_valid` is low and `core_done` is low while no request is made.
- R2: A request of any kind (`core_op` 0 load, 1 fetch, 2 store; 3 acts as load) to a Modified line with a matching tag completes in the same cycle with `core_hit`=1 and sends no message. A load or fetch returns the line data. A store writes `core_wdata` and returns it.
- R3: A request to an Invalid line sends a GETX (`msg_type`=0) for the request address to the directory node `DIR_ID` in the next cycle and does not complete.
- R4: Incoming data (`in_type`=0) for the pending miss completes the request in that cycle with `core_hit`=0. It returns `in_data`, or `core_wdata` for a store, and the line becomes Modified with that value.
- R5: A request whose line holds a different tag in any state other than Invalid stalls without a message.
- R6: A request to a line in a transient state (miss pending, writeback pending) stalls and sends no new message.
- R7: `repl_req` on a Modified line sends a writeback (`msg_type`=1) with the line address and data to the directory next cycle. The line stays busy until an ACK (`in_type`=2) makes it Invalid. `repl_req` on a line that is not Modified has no effect.
- R8: An invalidation (`in_type`=4) for a Modified line behaves exactly like a replacement.
- R9: A forward (`in_type`=1) for a Modified line sends a data message (`msg_type`=2) with the line data to node `in_src` next cycle, and the line becomes Invalid.
- R10: A forward that arrives while a writeback is pending sends the held data to `in_src`, and the line is then freed by the ACK or NACK (`in_type`=3). If the NACK comes first, the line keeps its data until the forward arrives, serves it and becomes Invalid.
- R11: In a cycle with an incoming message, a replacement trigger is dropped and a core request is neither served as a hit nor issued as a miss. In a cycle with `repl_req`, the core request is stalled.
- R12: At most one line is waiting for a fill at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req | input | 1 | Core request, held until done |
| core_op | input | 2 | 0 load, 1 fetch, 2 store |
| core_addr | input | AW | Line address of the request |
| core_wdata | input | DW | Store data |
| core_done | output | 1 | Request completes this cycle |
| core_hit | output | 1 | Completion was a hit |
| core_rdata | output | DW | Line value after the access |
| repl_req | input | 1 | Evict the line named by repl_idx |
| repl_idx | input | IW | Line index to evict |
| in_valid | input | 1 | Incoming message present |
| in_type | input | 3 | 0 data, 1 forward, 2 ack, 3 nack, 4 invalidate |
| in_addr | input | AW | Address of the incoming message |
| in_data | input | DW | Fill data |
| in_src | input | NW | Node that asked for a forward |
| msg_valid | output | 1 | Outgoing message present |
| msg_type | output | 2 | 0 GETX, 1 writeback, 2 data |
| msg_addr | output | AW | Address of the outgoing message |
| msg_data | output | DW | Data carried by the message |
| msg_dest | output | NW | Destination node |

## Verification
The assertions check, on every cycle, that no more than one line waits for a fill. They also check that a hit never produces a message, that nothing completes without a request, that an incoming message blocks hits, and that each replacement or forward on a Modified line yields the matching message one cycle later. The bench scenarios cover what only shows over a sequence of steps: the value a store leaves behind, the line becoming free after ACK or NACK (seen as a fresh GETX), the held data reaching the forward requester during a writeback, and the dropped replacement leaving its line intact.

// File: rtl/mi_cache_ctrl.sv
module mi_cache_ctrl #(
  parameter int AW = 12,
  parameter int DW = 32,
  parameter int LINES = 4,
  parameter int NW = 3,
  parameter int DIR_ID = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     core_req,
  input  logic [1:0]               core_op,
  input  logic [AW-1:0]            core_addr,
  input  logic [DW-1:0]            core_wdata,
  output logic                     core_done,
  output logic                     core_hit,
  output logic [DW-1:0]            core_rdata,
  input  logic                     repl_req,
  input  logic [$clog2(LINES)-1:0] repl_idx,
  input  logic                     in_valid,
  input  logic [2:0]               in_type,
  input  logic [AW-1:0]            in_addr,
  input  logic [DW-1:0]            in_data,
  input  logic [NW-1:0]            in_src,
  output logic                     msg_valid,
  output logic [1:0]               msg_type,
  output logic [AW-1:0]            msg_addr,
  output logic [DW-1:0]            msg_data,
  output logic [NW-1:0]            msg_dest
);
  localparam int IW = $clog2(LINES);
  localparam int TW = AW - IW;

  typedef enum logic [2:0] {S_I, S_M, S_IM, S_MI, S_MIF, S_MIN} lst_t;
  localparam logic [2:0] IN_DATA = 3'd0, IN_FWD = 3'd1, IN_ACK = 3'd2,
                         IN_NACK = 3'd3, IN_INV = 3'd4;
  localparam logic [1:0] OUT_GETX = 2'd0, OUT_WB = 2'd1, OUT_DATA = 2'd2;

  lst_t          st  [LINES];
  logic [TW-1:0] tg  [LINES];
  logic [DW-1:0] dat [LINES];

  logic [IW-1:0] c_idx, n_idx;
  logic [TW-1:0] c_tag, n_tag;
  logic c_match, n_match, is_store, hit, issue, fill, repl_go;

  assign c_idx    = core_addr[IW-1:0];
  assign c_tag    = core_addr[AW-1:IW];
  assign n_idx    = in_addr[IW-1:0];
  assign n_tag    = in_addr[AW-1:IW];
  assign c_match  = tg[c_idx] == c_tag;
  assign n_match  = tg[n_idx] == n_tag;
  assign is_store = core_op == 2'd2;

  assign hit   = core_req && !in_valid && !repl_req && st[c_idx] == S_M && c_match;
  assign issue = core_req && !in_valid && !repl_req && st[c_idx] == S_I;
  assign fill  = in_valid && in_type == IN_DATA && st[n_idx] == S_IM && n_match;
  assign repl_go = repl_req && !in_valid && st[repl_idx] == S_M;

  assign core_done  = hit || (fill && core_req);
  assign core_hit   = hit;
  assign core_rdata = is_store ? core_wdata : (hit ? dat[c_idx] : in_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st[i] <= S_I;
      msg_valid <= 1'b0;
      msg_type  <= OUT_GETX;
      msg_addr  <= '0;
      msg_data  <= '0;
      msg_dest  <= '0;
    end else begin
      msg_valid <= 1'b0;
      if (in_valid) begin
        case (in_type)
          IN_DATA: if (fill) begin
            st[n_idx]  <= S_M;
            dat[n_idx] <= (core_req && is_store) ? core_wdata : in_data;
          end
          IN_FWD: if (n_match && (st[n_idx] == S_M || st[n_idx] == S_MI || st[n_idx] == S_MIN)) begin
            msg_valid <= 1'b1;
            msg_type  <= OUT_DATA;
            msg_addr  <= in_addr;
            msg_data  <= dat[n_idx];
            msg_dest  <= in_src;
            st[n_idx] <= (st[n_idx] == S_MI) ? S_MIF : S_I;
          end
          IN_ACK: if (n_match && (st[n_idx] == S_MI || st[n_idx] == S_MIF))
            st[n_idx] <= S_I;
          IN_NACK: if (n_match) begin
            if (st[n_idx] == S_MI)  st[n_idx] <= S_MIN;
            if (st[n_idx] == S_MIF) st[n_idx] <= S_I;
          end
          IN_INV: if (n_match && st[n_idx] == S_M) begin
            msg_valid <= 1'b1;
            msg_type  <= OUT_WB;
            msg_addr  <= in_addr;
            msg_data  <= dat[n_idx];
            msg_dest  <= NW'(DIR_ID);
            st[n_idx] <= S_MI;
          end
          default: ;
        endcase
      end else if (repl_go) begin
        msg_valid    <= 1'b1;
        msg_type     <= OUT_WB;
        msg_addr     <= {tg[repl_idx], repl_idx};
        msg_data     <= dat[repl_idx];
        msg_dest     <= NW'(DIR_ID);
        st[repl_idx] <= S_MI;
      end else if (hit && is_store) begin
        dat[c_idx] <= core_wdata;
      end else if (issue) begin
        msg_valid  <= 1'b1;
        msg_type   <= OUT_GETX;
        msg_addr   <= core_addr;
        msg_data   <= '0;
        msg_dest   <= NW'(DIR_ID);
        st[c_idx]  <= S_IM;
        tg[c_idx]  <= c_tag;
      end
    end
  end

  logic [LINES-1:0] im_vec;
  always_comb
    for (int i = 0; i < LINES; i++) im_vec[i] = st[i] == S_IM;

  // R12
  one_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(im_vec) <= 1);

  // R2
  hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_done && core_hit |=> !msg_valid);

  // R4
  done_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_done |-> core_req);

  // R11
  prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> !core_hit);

  // R7
  repl_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    repl_req && !in_valid && st[repl_idx] == S_M |=> msg_valid && msg_type == OUT_WB);

  // R9
  fwd_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_type == IN_FWD && n_match && st[n_idx] == S_M
    |=> msg_valid && msg_type == OUT_DATA && msg_dest == $past(in_src));
endmodule

// File: tb/mi_cache_ctrl_tb.sv
module mi_cache_ctrl_tb_top;
  localparam int AW = 12, DW = 32, LINES = 4, NW = 3, IW = 2;

  logic clk = 0, rst_n = 0;
  logic core_req = 0; logic [1:0] core_op = 0;
  logic [AW-1:0] core_addr = 0; logic [DW-1:0] core_wdata = 0;
  logic core_done, core_hit; logic [DW-1:0] core_rdata;
  logic repl_req = 0; logic [IW-1:0] repl_idx = 0;
  logic in_valid = 0; logic [2:0] in_type = 0;
  logic [AW-1:0] in_addr = 0; logic [DW-1:0] in_data = 0; logic [NW-1:0] in_src = 0;
  logic msg_valid; logic [1:0] msg_type; logic [AW-1:0] msg_addr;
  logic [DW-1:0] msg_data; logic [NW-1:0] msg_dest;

  mi_cache_ctrl dut_i (.*);

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  bit done_flag = 0;
  bit mval [LINES];
  logic [AW-IW-1:0] mtg [LINES];
  logic [DW-1:0] mdt [LINES];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk(input int tag, input int idx);
    return {tag[AW-IW-1:0], idx[IW-1:0]};
  endfunction

  function automatic logic [DW-1:0] exp_val(input logic [1:0] op, input logic [DW-1:0] w,
                                            input logic [DW-1:0] old);
    return (op == 2'd2) ? w : old;
  endfunction

  task automatic step(); @(posedge clk); @(negedge clk); endtask

  task automatic clear();
    core_req = 0; repl_req = 0; in_valid = 0;
  endtask

  task automatic send(input logic [2:0] t, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic [NW-1:0] s);
    in_valid = 1; in_type = t; in_addr = a; in_data = d; in_src = s;
  endtask

  task automatic req(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] w);
    core_req = 1; core_op = op; core_addr = a; core_wdata = w;
  endtask

  task automatic chk_msg(input string r, input logic [1:0] t, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input logic [NW-1:0] dst, input bit cmp_data);
    chk({r, " msg_valid"}, msg_valid, 1);
    chk({r, " msg_type"}, msg_type, t);
    chk({r, " msg_addr"}, msg_addr, a);
    chk({r, " msg_dest"}, msg_dest, dst);
    if (cmp_data) chk({r, " msg_data"}, msg_data, d);
  endtask

  task automatic do_hit(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] w);
    int i = int'(a[IW-1:0]);
    logic [DW-1:0] e = exp_val(op, w, mdt[i]);
    req(op, a, w); #1;
    chk("R2 hit done", core_done, 1);
    chk("R2 hit flag", core_hit, 1);
    chk("R2 hit rdata", core_rdata, e);
    step(); clear();
    chk("R2 hit no msg", msg_valid, 0);
    mdt[i] = e;
  endtask

  task automatic do_miss(input logic [1:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] w, input logic [DW-1:0] f);
    int i = int'(a[IW-1:0]);
    logic [DW-1:0] e = exp_val(op, w, f);
    req(op, a, w); #1;
    chk("R3 miss not done", core_done, 0);
    step();
    chk_msg("R3 getx", 2'd0, a, 0, 0, 0);
    step();
    chk("R6 pending stall done", core_done, 0);
    chk("R6 pending no msg", msg_valid, 0);
    send(3'd0, a, f, 0); #1;
    chk("R4 fill done", core_done, 1);
    chk("R4 fill hit flag", core_hit, 0);
    chk("R4 fill rdata", core_rdata, e);
    step(); clear();
    mval[i] = 1; mtg[i] = a[AW-1:IW]; mdt[i] = e;
  endtask

  task automatic do_evict(input int i, input bit use_inv);
    logic [AW-1:0] a = {mtg[i], i[IW-1:0]};
    if (use_inv) send(3'd4, a, 0, 0);
    else begin repl_req = 1; repl_idx = i[IW-1:0]; end
    step(); clear();
    if (use_inv) chk_msg("R8 inv wb", 2'd1, a, mdt[i], 0, 1);
    else chk_msg("R7 repl wb", 2'd1, a, mdt[i], 0, 1);
    send(3'd2, a, 0, 0); step(); clear();
    chk("R7 ack quiet", msg_valid, 0);
    mval[i] = 0;
  endtask

  task automatic do_fwd(input int i, input logic [NW-1:0] node);
    logic [AW-1:0] a = {mtg[i], i[IW-1:0]};
    send(3'd1, a, 0, node); step(); clear();
    chk_msg("R9 fwd data", 2'd2, a, mdt[i], node, 1);
    mval[i] = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < LINES; i++) begin mval[i] = 0; mtg[i] = 0; mdt[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset msg", msg_valid, 0);
    chk("R1 reset done", core_done, 0);
    repl_req = 1; repl_idx = 0; step(); clear();
    chk("R7 repl on invalid ignored", msg_valid, 0);

    // R4 store miss merges write data; R2 load/fetch then see it
    do_miss(2'd2, mk(1, 1), 32'hAAAA_0001, 32'h1234_5678);
    do_hit(2'd0, mk(1, 1), 0);
    do_hit(2'd1, mk(1, 1), 0);
    do_hit(2'd2, mk(1, 1), 32'h0BAD_F00D);
    do_hit(2'd0, mk(1, 1), 0);

    // R11: forward on line 2 with replacement and hit on line 1 in the same cycle
    do_miss(2'd0, mk(2, 2), 0, 32'h2222_2222);
    send(3'd1, mk(2, 2), 0, 3'd6);
    repl_req = 1; repl_idx = 1; req(2'd0, mk(1, 1), 0); #1;
    chk("R11 core blocked", core_done, 0);
    step(); clear();
    chk_msg("R11 only fwd reply", 2'd2, mk(2, 2), 32'h2222_2222, 3'd6, 1);
    mval[2] = 0;
    do_hit(2'd0, mk(1, 1), 0);

    // R5 conflict stall
    req(2'd0, mk(3, 1), 0); #1;
    chk("R5 conflict not done", core_done, 0);
    step(); clear();
    chk("R5 conflict no msg", msg_valid, 0);

    // R10 writeback pending, forward, then NACK
    repl_req = 1; repl_idx = 1; step(); clear();
    chk_msg("R7 repl wb", 2'd1, mk(1, 1), 32'h0BAD_F00D, 0, 1);
    req(2'd0, mk(1, 1), 0); #1;
    chk("R6 wb pending stall", core_done, 0);
    step(); clear();
    chk("R6 wb pending no msg", msg_valid, 0);
    send(3'd1, mk(1, 1), 0, 3'd5); step(); clear();
    chk_msg("R10 held data fwd", 2'd2, mk(1, 1), 32'h0BAD_F00D, 3'd5, 1);
    send(3'd3, mk(1, 1), 0, 0); step(); clear();
    chk("R10 nack quiet", msg_valid, 0);
    mval[1] = 0;
    do_miss(2'd0, mk(1, 1), 0, 32'h3333_0000);

    // R10 NACK before forward
    repl_req = 1; repl_idx = 1; step(); clear();
    chk_msg("R7 repl wb", 2'd1, mk(1, 1), 32'h3333_0000, 0, 1);
    send(3'd3, mk(1, 1), 0, 0); step(); clear();
    chk("R10 nack first quiet", msg_valid, 0);
    send(3'd1, mk(1, 1), 0, 3'd4); step(); clear();
    chk_msg("R10 late fwd", 2'd2, mk(1, 1), 32'h3333_0000, 3'd4, 1);
    mval[1] = 0;
    do_miss(2'd1, mk(1, 1), 0, 32'h4444_0000);

    // R8 invalidation, R9 forward on modified line
    do_evict(1, 1);
    do_miss(2'd0, mk(0, 3), 0, 32'h5555_0000);
    do_fwd(3, 3'd2);
    do_miss(2'd0, mk(0, 3), 0, 32'h6666_0000);

    // random mix
    void'($urandom(32'h5EED_0042));
    for (int n = 0; n < 400; n++) begin
      int r = $urandom_range(0, 9);
      int i = $urandom_range(0, LINES - 1);
      int t = $urandom_range(0, 3);
      logic [1:0] op = 2'($urandom_range(0, 2));
      logic [DW-1:0] w = $urandom;
      if (r < 7) begin
        if (mval[i] && mtg[i] == t[AW-IW-1:0]) do_hit(op, mk(t, i), w);
        else begin
          if (mval[i]) begin
            req(op, mk(t, i), w); #1;
            chk("R5 conflict not done", core_done, 0);
            step(); clear();
            chk("R5 conflict no msg", msg_valid, 0);
            do_evict(i, $urandom_range(0, 1));
          end
          do_miss(op, mk(t, i), w, $urandom);
        end
      end else if (mval[i]) begin
        if (r < 9) do_evict(i, $urandom_range(0, 1));
        else do_fwd(i, 3'($urandom_range(1, 7)));
      end
    end

    done_flag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule